// File: doc/BRIEF.md
# Serial Shift-Add Modular Multiplier

This block computes the residue of the product of two unsigned operands modulo a third value, (i*j) mod p, for 0 <= i, j < p < 2^31. It never builds the double-width product. The smaller operand is scanned one bit per clock, least significant bit first. A second operand register doubles on every step. When the scanned bit is set, the doubling value is added into a running residue. Each of these two values is brought back below p by a single conditional subtraction, so the datapath needs only adders and comparators.

The caller applies the two operands and the modulus together with a one-cycle start pulse while the block is idle. The block answers with a one-cycle done pulse, and the residue appears on the result port at the same time. Run time depends on the data. The loop ends as soon as the scanned operand runs out of set bits, so small operands finish early and a zero operand finishes almost at once.

Top module: `serial_modmul`

## Requirements
- R1: After a completed operation, result equals (opA*opB) mod modulus for any 0 <= opA, opB < modulus < 2^31.
- R2: When either operand is 0, result is 0 and done rises one clock edge after the edge that accepted start.
- R3: With L the bit length of min(opA, opB) (L = 0 for a zero operand), done is high in the cycle that follows the (L+1)-th rising edge after the edge that accepted start.
- R4: Swapping opA and opB gives the same result and the same latency, because the smaller operand is always the one scanned.
- R5: done is high for exactly one cycle per operation. busy is high from the edge that accepts start until the edge that raises done, and busy is low while done is high.
- R6: result changes only at the edge that raises done, and then holds its value until the next completion.
- R7: A start pulse given while busy is high is ignored. The running operation keeps its operands, result and latency.
- R8: With modulus = 2^31-1 and both operands equal to modulus-1, the result is correct. The running residue and the doubled addend stay below modulus at every step, so no sum can overflow.
- R9: After reset, busy, done and result are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| opA | input | 31 | First operand, below modulus |
| opB | input | 31 | Second operand, below modulus |
| modulus | input | 31 | Modulus p, 1 <= p < 2^31 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 31 | Residue of the last completed operation |

## Verification
Random moduli at many magnitudes, with operands drawn below them, exercise the residue against a 64-bit reference and check the latency derived from the smaller operand's bit length. Each random pair is also run in swapped order, which shows whether the operand ordering picks the shorter scan. Directed cases cover zero operands (early exit), a modulus of 1, operands of 1 and modulus-1, and the largest modulus with maximal operands. The largest-modulus case shows up any overflow of the 32-bit sums. A start pulse injected during a long operation shows whether the operands are resampled while busy.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic {
    MM_IDLE = 1'b0,
    MM_RUN  = 1'b1
  } mmState_t;

  typedef struct packed {
    logic load;    // capture operands, order them, clear residue
    logic step;    // process one multiplier bit
    logic finish;  // publish residue to the result register
  } mmCtrl_t;

endpackage

// File: rtl/mm_cond_sub.sv
module mm_cond_sub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  input  logic [WIDTH-1:0] modulus,
  output logic [WIDTH-1:0] reduced
);

  logic             geMod;
  logic [WIDTH-1:0] diff;

  always_comb begin
    diff    = value - modulus;
    geMod   = (value >= modulus);
    reduced = geMod ? diff : value;
  end

endmodule

// File: rtl/mm_control.sv
module mm_control
  import mm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    mplrZero,
  output mmCtrl_t ctrl,
  output logic    busy,
  output logic    done
);

  mmState_t stateQ, stateD;
  logic     doneQ;

  always_comb begin
    ctrl        = '0;
    stateD      = stateQ;
    ctrl.load   = (stateQ == MM_IDLE) && start;
    ctrl.step   = (stateQ == MM_RUN) && !mplrZero;
    ctrl.finish = (stateQ == MM_RUN) && mplrZero;
    if (ctrl.load)   stateD = MM_RUN;
    if (ctrl.finish) stateD = MM_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= MM_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= ctrl.finish;
    end
  end

  assign busy = (stateQ == MM_RUN);
  assign done = doneQ;

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: busy and done never overlap
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R3: an exhausted multiplier ends the run on the next edge
  assert_exit_on_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mplrZero) |=> (done && !busy));

  // R7: start while busy does not restart or end the run early
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !mplrZero) |=> busy);

endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter  int DATA_W = 31,
  localparam int ACC_W  = DATA_W + 1,
  localparam int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mmCtrl_t           ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] modulus,
  output logic              mplrZero,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] mplrQ;
  logic [ACC_W-1:0]  addendQ;
  logic [ACC_W-1:0]  residueQ;
  logic [DATA_W-1:0] modQ;
  logic [DATA_W-1:0] resultQ;

  logic              aSmaller;
  logic [DATA_W-1:0] smallOp, bigOp;
  logic [ACC_W-1:0]  modExt;
  logic [ACC_W-1:0]  residueNext;

  // lane 0 reduces residue+addend, lane 1 reduces the doubled addend
  logic [LANES-1:0][ACC_W-1:0] laneIn;
  logic [LANES-1:0][ACC_W-1:0] laneOut;

  always_comb begin
    aSmaller  = (opA < opB);
    smallOp   = aSmaller ? opA : opB;
    bigOp     = aSmaller ? opB : opA;
    modExt    = {1'b0, modQ};
    laneIn[0] = residueQ + addendQ;
    laneIn[1] = {addendQ[ACC_W-2:0], 1'b0};
    residueNext = mplrQ[0] ? laneOut[0] : residueQ;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_reduce
    mm_cond_sub #(.WIDTH(ACC_W)) u_sub (
      .value   (laneIn[g]),
      .modulus (modExt),
      .reduced (laneOut[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mplrQ    <= '0;
      addendQ  <= '0;
      residueQ <= '0;
      modQ     <= '0;
      resultQ  <= '0;
    end else begin
      if (ctrl.load) begin
        mplrQ    <= smallOp;
        addendQ  <= {1'b0, bigOp};
        residueQ <= '0;
        modQ     <= modulus;
      end else if (ctrl.step) begin
        mplrQ    <= mplrQ >> 1;
        addendQ  <= laneOut[1];
        residueQ <= residueNext;
      end
      if (ctrl.finish) resultQ <= residueQ[DATA_W-1:0];
    end
  end

  assign mplrZero = (mplrQ == '0);
  assign result   = resultQ;

  // R8: operands of a step are already reduced, so sums fit in ACC_W
  assert_residue_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> (residueQ < modExt));

  assert_addend_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> (addendQ < modExt));

  // R6: result register only moves when a completion was signalled
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultQ) |-> $past(ctrl.finish));

  // R2: a zero operand leaves nothing to scan
  assert_zero_exit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && (opA == '0 || opB == '0)) |=> mplrZero);

endmodule

// File: rtl/serial_modmul.sv
module serial_modmul
  import mm_pkg::*;
#(
  parameter int DATA_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] modulus,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  mmCtrl_t ctrl;
  logic    mplrZero;

  mm_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mplrZero (mplrZero),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done)
  );

  mm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .modulus  (modulus),
    .mplrZero (mplrZero),
    .result   (result)
  );

endmodule

// File: tb/sim_serial_modmul.sv
`timescale 1ns/1ps
module sim_serial_modmul;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [30:0] opA = '0, opB = '0, modulus = 31'd1;
  logic        busy, done;
  logic [30:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  serial_modmul u0 (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .modulus(modulus), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned refMod(input longint unsigned a, b, m);
    return (a * b) % m;
  endfunction

  function automatic int bitLen(input logic [30:0] v);
    int n = 0;
    for (int k = 0; k < 31; k++) if (v[k]) n = k + 1;
    return n;
  endfunction

  // Runs one operation; optionally injects a start with other operands mid-run.
  task automatic runOp(input logic [30:0] a, b, m, input bit inject,
                       output logic [30:0] res, output int lat);
    logic [30:0] held;
    @(negedge clk);
    opA = a; opB = b; modulus = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk(busy == 1'b1, "R5 busy after start", busy, 1);
    while (!done && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (!done) begin
        if (inject && lat == 2) begin
          opA = 31'd5; opB = 31'd7; modulus = 31'd11; start = 1'b1;
        end else begin
          start = 1'b0;
        end
      end else begin
        chk(busy == 1'b0, "R5 busy low at done", busy, 0);
      end
    end
    start = 1'b0;
    res = result;
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(result == held, "R6 result held", result, held);
  endtask

  task automatic fullCheck(input logic [30:0] a, b, m, input string tag);
    logic [30:0] r1, r2;
    int l1, l2, expLat;
    longint unsigned expRes;
    expRes = refMod(a, b, m);
    expLat = bitLen((a < b) ? a : b) + 1;
    runOp(a, b, m, 1'b0, r1, l1);
    chk(r1 == expRes, {tag, " R1 residue"}, r1, expRes);
    chk(l1 == expLat, {tag, " R3 latency"}, l1, expLat);
    runOp(b, a, m, 1'b0, r2, l2);
    chk(r2 == r1 && l2 == l1, {tag, " R4 swapped"}, r2, r1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [30:0] r;
    int l;
    logic [30:0] m, a, b;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 1'b0, "R9 busy at reset", busy, 0);
    chk(done == 1'b0, "R9 done at reset", done, 0);
    chk(result == 31'd0, "R9 result at reset", result, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: zero operands, early exit
    runOp(31'd0, 31'd12345, 31'd99991, 1'b0, r, l);
    chk(r == 0, "R2 zero residue", r, 0);
    chk(l == 1, "R2 zero latency", l, 1);
    runOp(31'd777, 31'd0, 31'd1000, 1'b0, r, l);
    chk(r == 0 && l == 1, "R2 zero second operand", l, 1);

    // directed corners
    fullCheck(31'd0, 31'd0, 31'd1, "mod1");
    fullCheck(31'd1, 31'd1, 31'd2, "ones");
    fullCheck(31'd1, 31'd999, 31'd1000, "one_by_pm1");
    fullCheck(31'd999, 31'd999, 31'd1000, "pm1_sq");
    fullCheck(31'h7FFF_FFFD, 31'h7FFF_FFFD, 31'h7FFF_FFFE, "near_top");
    // R8: largest modulus, maximal operands
    runOp(31'h7FFF_FFFE, 31'h7FFF_FFFE, 31'h7FFF_FFFF, 1'b0, r, l);
    chk(r == refMod(64'h7FFF_FFFE, 64'h7FFF_FFFE, 64'h7FFF_FFFF), "R8 max operands",
        r, refMod(64'h7FFF_FFFE, 64'h7FFF_FFFE, 64'h7FFF_FFFF));
    chk(l == 32, "R8 max latency", l, 32);

    // R7: start while busy ignored
    a = 31'h1234_5678; b = 31'h2345_6789; m = 31'h7000_0001;
    runOp(a, b, m, 1'b1, r, l);
    chk(r == refMod(a, b, m), "R7 result unaffected", r, refMod(a, b, m));
    chk(l == bitLen(a) + 1, "R7 latency unaffected", l, bitLen(a) + 1);
    runOp(31'd3, 31'd4, 31'd11, 1'b0, r, l);
    chk(r == 31'd1, "R7 next op normal", r, 1);

    // constrained random across modulus magnitudes
    for (int t = 0; t < 150; t++) begin
      m = 31'($urandom) >> ($urandom % 31);
      if (m == 0) m = 31'd1;
      a = 31'($urandom % m);
      b = 31'($urandom % m);
      if (t % 7 == 0) b = m - 31'd1;
      fullCheck(a, b, m, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule